// File: doc/BRIEF.md
# Cache Miss Type Classifier

This monitor sits beside a direct-mapped cache and watches the byte addresses that the cache is asked for. Each access is labelled as one of four outcomes: a hit, a cold (compulsory) miss, a conflict miss or a capacity miss. Only block addresses matter, so no data is stored, and writes and memory traffic are outside its scope.

To tell the three miss causes apart, the classifier keeps three structures. The first is its own copy of the direct-mapped tag array. The second is a first-touch bitmap that records every block address ever referenced. The third is a fully-associative shadow cache with true LRU replacement and the same number of lines as the direct-mapped cache. All three are updated on every access. The label leaves the block one cycle after the access as a one-hot vector. A saturating event counter for each class runs beside it.

Top module: `cmc_classifier`

## Requirements
- R1: After reset, class_valid_o is 0, all four counters read 0, the tag store, shadow cache and first-touch bitmap are empty, and so the first access to any block is cold.
- R2: The byte address splits into block offset (bits OFF_W-1:0), set index (the next IDX_W bits) and tag (the remaining upper bits). Accesses that differ only in the offset refer to the same block.
- R3: An access whose set holds a valid entry with a matching tag is a hit (class_o bit 0), whatever the other structures hold.
- R4: A direct-mapped miss on a block never referenced since reset is cold (class_o bit 1).
- R5: A direct-mapped miss on a block that was referenced before and is still held by the fully-associative shadow is a conflict miss (class_o bit 2). With 8 sets, blocks 0 and 8 accessed as 0, 8, 0, 8 give cold, cold, conflict, conflict.
- R6: A direct-mapped miss on a block that was referenced before but is absent from the shadow is a capacity miss (class_o bit 3). Cycling 9 distinct blocks through an 8-line cache produces this outcome.
- R7: The shadow has one line per direct-mapped set, uses true LRU, and refreshes recency on every access, including direct-mapped hits.
- R8: class_valid_o rises, and class_o carries exactly one set bit, in the cycle after each accepted access. With valid_i low, class_valid_o is 0 in the next cycle.
- R9: Each access increments exactly the counter of its class, and that counter is visible in the same cycle as the label. Idle cycles leave all counters unchanged.
- R10: Each counter saturates at 2^CNT_W-1 and stays there, while the other counters keep counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Access strobe |
| addr_i | input | ADDR_W | Byte address of the access |
| class_valid_o | output | 1 | Label valid, one cycle after the access |
| class_o | output | 4 | One-hot label: bit0 hit, bit1 cold, bit2 conflict, bit3 capacity |
| hit_cnt_o | output | CNT_W | Saturating hit count |
| cold_cnt_o | output | CNT_W | Saturating cold-miss count |
| conflict_cnt_o | output | CNT_W | Saturating conflict-miss count |
| capacity_cnt_o | output | CNT_W | Saturating capacity-miss count |

## Verification
Four directed patterns each isolate one cause:
- An alternating two-block pattern in one set yields only conflicts after the first touches.
- Offset-only variation exercises the address split.
- A warm-up that re-touches one block before a set collision shows whether shadow recency is refreshed on hits. Without the refresh, the result would read capacity instead of conflict.
- A nine-block cycle forces capacity misses.

Random addresses drawn from a small block range with random offsets mix all four outcomes, and each outcome is compared against a recency-list model. A long run of hits drives one counter into saturation while another counter is still checked for increments.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
  typedef enum logic [1:0] {
    CLS_HIT  = 2'd0,
    CLS_COLD = 2'd1,
    CLS_CONF = 2'd2,
    CLS_CAP  = 2'd3
  } cls_e;
  localparam int unsigned NUM_CLS = 4;
endpackage

// File: rtl/cmc_dm_tags.sv
module cmc_dm_tags #(
  parameter int unsigned IDX_W = 3,
  parameter int unsigned TAG_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             hit_o
);
  localparam int unsigned SETS = 1 << IDX_W;

  logic [SETS-1:0]  vld_q;
  logic [TAG_W-1:0] tag_q [SETS];

  assign hit_o = vld_q[idx_i] && (tag_q[idx_i] == tag_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < SETS; i++) tag_q[i] <= '0;
    end else if (acc_i) begin
      vld_q[idx_i] <= 1'b1;
      tag_q[idx_i] <= tag_i;
    end
  end

  // R3
  fill_then_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |=> (vld_q[$past(idx_i)] && tag_q[$past(idx_i)] == $past(tag_i)));
endmodule

// File: rtl/cmc_seen_map.sv
module cmc_seen_map #(
  parameter int unsigned BLK_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic [BLK_W-1:0] blk_i,
  output logic             seen_o
);
  localparam int unsigned NBLK = 1 << BLK_W;

  logic [NBLK-1:0] map_q;

  assign seen_o = map_q[blk_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    map_q <= '0;
    else if (acc_i) map_q[blk_i] <= 1'b1;
  end

  // R4
  seen_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |=> map_q[$past(blk_i)]);
endmodule

// File: rtl/cmc_lru_shadow.sv
module cmc_lru_shadow #(
  parameter int unsigned LINES = 8,
  parameter int unsigned BLK_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic [BLK_W-1:0] blk_i,
  output logic             hit_o
);
  localparam int unsigned AGE_W = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int unsigned WAY_W = AGE_W;

  logic [LINES-1:0] vld_q;
  logic [BLK_W-1:0] tag_q [LINES];
  logic [AGE_W-1:0] age_q [LINES];
  logic [LINES-1:0] hit_vec;
  logic [WAY_W-1:0] hit_way, vic_way;
  logic             has_free;

  for (genvar w = 0; w < LINES; w++) begin : g_cmp
    assign hit_vec[w] = vld_q[w] && (tag_q[w] == blk_i);
  end

  assign hit_o = |hit_vec;

  always_comb begin
    hit_way  = '0;
    vic_way  = '0;
    has_free = 1'b0;
    for (int w = LINES - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
      if (!vld_q[w]) begin
        vic_way  = WAY_W'(w);
        has_free = 1'b1;
      end
    end
    if (!has_free) begin
      for (int w = 0; w < LINES; w++)
        if (age_q[w] == AGE_W'(LINES - 1)) vic_way = WAY_W'(w);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int w = 0; w < LINES; w++) begin
        tag_q[w] <= '0;
        age_q[w] <= '0;
      end
    end else if (acc_i) begin
      for (int w = 0; w < LINES; w++) begin
        if (hit_o) begin
          if (WAY_W'(w) == hit_way) age_q[w] <= '0;
          else if (vld_q[w] && age_q[w] < age_q[hit_way]) age_q[w] <= age_q[w] + AGE_W'(1);
        end else if (WAY_W'(w) == vic_way) begin
          vld_q[w] <= 1'b1;
          tag_q[w] <= blk_i;
          age_q[w] <= '0;
        end else if (vld_q[w]) begin
          age_q[w] <= age_q[w] + AGE_W'(1);
        end
      end
    end
  end

  // R7
  no_dup_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));
  // R7
  mru_after_acc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |=> hit_o || (blk_i != $past(blk_i)));
endmodule

// File: rtl/cmc_classifier.sv
module cmc_classifier
  import cmc_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned OFF_W  = 2,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              class_valid_o,
  output logic [3:0]        class_o,
  output logic [CNT_W-1:0]  hit_cnt_o,
  output logic [CNT_W-1:0]  cold_cnt_o,
  output logic [CNT_W-1:0]  conflict_cnt_o,
  output logic [CNT_W-1:0]  capacity_cnt_o
);
  localparam int unsigned BLK_W = ADDR_W - OFF_W;
  localparam int unsigned TAG_W = BLK_W - IDX_W;
  localparam int unsigned LINES = 1 << IDX_W;

  logic [BLK_W-1:0] blk;
  logic             dm_hit, seen, sh_hit;
  cls_e             cls_d;
  logic [3:0]       cls_q;
  logic             cv_q;
  logic [CNT_W-1:0] cnt_q [NUM_CLS];

  assign blk = addr_i[ADDR_W-1:OFF_W];

  cmc_dm_tags #(.IDX_W(IDX_W), .TAG_W(TAG_W)) i_dm (
    .clk_i, .rst_ni, .acc_i(valid_i),
    .idx_i(blk[IDX_W-1:0]), .tag_i(blk[BLK_W-1:IDX_W]), .hit_o(dm_hit));

  cmc_seen_map #(.BLK_W(BLK_W)) i_seen (
    .clk_i, .rst_ni, .acc_i(valid_i), .blk_i(blk), .seen_o(seen));

  cmc_lru_shadow #(.LINES(LINES), .BLK_W(BLK_W)) i_shadow (
    .clk_i, .rst_ni, .acc_i(valid_i), .blk_i(blk), .hit_o(sh_hit));

  always_comb begin
    if (dm_hit)     cls_d = CLS_HIT;
    else if (!seen) cls_d = CLS_COLD;
    else if (sh_hit) cls_d = CLS_CONF;
    else            cls_d = CLS_CAP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cv_q  <= 1'b0;
      cls_q <= '0;
    end else begin
      cv_q  <= valid_i;
      cls_q <= valid_i ? (4'b0001 << cls_d) : 4'b0000;
    end
  end

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cnt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q[c] <= '0;
      else if (valid_i && cls_d == cls_e'(c) && cnt_q[c] != '1)
        cnt_q[c] <= cnt_q[c] + CNT_W'(1);
    end
  end

  assign class_valid_o  = cv_q;
  assign class_o        = cls_q;
  assign hit_cnt_o      = cnt_q[0];
  assign cold_cnt_o     = cnt_q[1];
  assign conflict_cnt_o = cnt_q[2];
  assign capacity_cnt_o = cnt_q[3];

  // R8
  onehot_label_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    class_valid_o |-> $onehot(class_o));
  // R8
  label_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> class_valid_o);
  // R9
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(hit_cnt_o) && $stable(cold_cnt_o) &&
                 $stable(conflict_cnt_o) && $stable(capacity_cnt_o) && !class_valid_o);
  // R10
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_cnt_o >= $past(hit_cnt_o) && cold_cnt_o >= $past(cold_cnt_o) &&
    conflict_cnt_o >= $past(conflict_cnt_o) && capacity_cnt_o >= $past(capacity_cnt_o));
  // R3
  hit_was_seen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dm_hit) |-> seen);
endmodule

// File: tb/test_cmc_classifier.sv
module test_cmc_classifier;
  localparam int CLK_PERIOD = 10;
  localparam int SATMAX = 65535;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [11:0] addr = '0;
  logic        class_valid;
  logic [3:0]  cls;
  logic [15:0] c_hit, c_cold, c_conf, c_cap;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  bit          m_dm_vld [8];
  logic [6:0]  m_dm_tag [8];
  bit          m_seen [1024];
  int          m_lst [8];
  int          m_n;
  int          m_cnt [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  cmc_classifier i_cmc_classifier (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .addr_i(addr),
    .class_valid_o(class_valid), .class_o(cls),
    .hit_cnt_o(c_hit), .cold_cnt_o(c_cold),
    .conflict_cnt_o(c_conf), .capacity_cnt_o(c_cap));

  task automatic chk(input string r, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) begin m_dm_vld[i] = 0; m_dm_tag[i] = '0; end
    for (int i = 0; i < 1024; i++) m_seen[i] = 0;
    for (int i = 0; i < 4; i++) m_cnt[i] = 0;
    m_n = 0;
  endtask

  task automatic model_acc(input logic [11:0] a, output int c);
    int blk, set, pos;
    logic [6:0] tag;
    blk = int'(a[11:2]);
    set = blk % 8;
    tag = 7'(blk / 8);
    pos = -1;
    for (int i = 0; i < m_n; i++) if (m_lst[i] == blk) pos = i;
    if (m_dm_vld[set] && m_dm_tag[set] == tag) c = 0;
    else if (!m_seen[blk]) c = 1;
    else if (pos >= 0) c = 2;
    else c = 3;
    m_dm_vld[set] = 1; m_dm_tag[set] = tag; m_seen[blk] = 1;
    if (pos < 0) begin
      if (m_n < 8) m_n++;
      pos = m_n - 1;
    end
    for (int i = pos; i > 0; i--) m_lst[i] = m_lst[i-1];
    m_lst[0] = blk;
    if (m_cnt[c] < SATMAX) m_cnt[c]++;
  endtask

  task automatic chk_cnts(input string r);
    chk(r, "hit_cnt", c_hit, m_cnt[0]);
    chk(r, "cold_cnt", c_cold, m_cnt[1]);
    chk(r, "conflict_cnt", c_conf, m_cnt[2]);
    chk(r, "capacity_cnt", c_cap, m_cnt[3]);
  endtask

  // called at a negedge; returns at the next negedge
  task automatic acc(input logic [11:0] a, input bit do_chk, input string r);
    int c;
    model_acc(a, c);
    valid = 1'b1; addr = a;
    @(negedge clk);
    valid = 1'b0;
    if (do_chk) chk(r, "class", {class_valid, cls}, {1'b1, 4'(4'b0001 << c)});
  endtask

  task automatic do_reset();
    valid = 1'b0;
    rst_n = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    do_reset();
    // R1
    chk("R1", "class_valid", class_valid, 0);
    chk_cnts("R1");

    // R4 then R5: blocks 0 and 8 share set 0
    acc(12'd0, 1, "R4");
    acc(12'd32, 1, "R4");
    acc(12'd0, 1, "R5");
    acc(12'd32, 1, "R5");
    chk_cnts("R9");
    // R2 / R3: offsets within block 8
    acc(12'd33, 1, "R2");
    acc(12'd35, 1, "R3");

    // R9 idle
    repeat (3) @(negedge clk);
    chk("R9", "idle class_valid", class_valid, 0);
    chk_cnts("R9");

    // R7: hit refreshes shadow recency
    do_reset();
    for (int b = 0; b < 8; b++) acc(12'(b * 4), 1, "R4");
    acc(12'd0, 1, "R3");
    acc(12'd32, 1, "R4");
    acc(12'd0, 1, "R7");

    // R6: nine-block working set
    do_reset();
    for (int b = 0; b < 9; b++) acc(12'(b * 4), 1, "R4");
    acc(12'd0, 1, "R6");
    chk_cnts("R6");

    // R8 random mix
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      logic [11:0] a;
      a = 12'((($urandom % 24) << 2) | ($urandom % 4));
      acc(a, 1, "R8");
      if (i % 100 == 0) chk_cnts("R9");
      if ($urandom % 5 == 0) @(negedge clk);
    end
    chk_cnts("R9");

    // R10 saturation
    do_reset();
    acc(12'd4, 1, "R4");
    for (int i = 0; i < 65600; i++) acc(12'd5, 0, "R10");
    chk("R10", "hit_cnt sat", c_hit, SATMAX);
    acc(12'd4, 1, "R10");
    chk("R10", "hit_cnt held", c_hit, SATMAX);
    acc(12'd4000, 1, "R4");
    chk("R10", "cold_cnt moves", c_cold, 2);
    chk_cnts("R10");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule